// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor with a 16-bit address bus and its memories. For every memory access it works out which target answers: a 4 KB page of banked RAM, a page of boot ROM, one half of the video window, or a dummy sink that absorbs writes aimed at ROM. A six-bit control register, loaded through an I/O write to one configurable port, picks the RAM bank for the lower 32 KB. The same register switches ROM and video off and moves the video window between two places.

The address space is handled as sixteen 4 KB pages, with the page number taken from A15..A12. When several mappings cover one page, video wins over ROM and ROM wins over RAM. Reads and writes are decoded separately. A write that lands on a ROM page is sent to the sink, so memory is not changed. After reset the control register is zero. For a fixed number of clock cycles the boot ROM also covers the bottom 16 KB, so the processor starts from ROM. The RAM and ROM arrays, DRAM refresh and the video controller are outside the block.

Top module: `bank_map_decoder`

## Requirements
- R1: After reset the control register is zero. While the boot overlay is active, an access to 0x0000-0x3FFF targets ROM, with ROM page equal to A13..A12. With the register at zero, 0x8000-0xBFFF is also ROM and 0xF000-0xFFFF is video.
- R2: A RAM access below 0x8000 gives ram_page = {ctl[5], ctl[1], ctl[0], 1'b0, A14..A12}. A RAM access at or above 0x8000 gives ram_page = {3'b000, 1'b1, A14..A12}.
- R3: When ctl[2] is 0, pages 0x8000-0xBFFF are ROM with rom_page = A13..A12. When ctl[2] is 1, those pages are RAM.
- R4: When ctl[3] is 0 the video window is enabled. ctl[4] = 0 places it at 0xF000-0xFFFF and ctl[4] = 1 places it at 0x8000-0x8FFF. When ctl[3] is 1, the page that would have been video is decoded as ROM or RAM.
- R5: Where mappings overlap, video takes priority over ROM and ROM takes priority over RAM.
- R6: Inside the video window, A11 = 0 asserts vid_lo_sel and A11 = 1 asserts vid_hi_sel.
- R7: A write to a ROM page asserts sink_sel and never rom_sel or ram_sel. A write to a video or RAM page is decoded as a read of the same page would be.
- R8: The control register loads io_wdata[5:0] only when io_wr is high and io_addr equals CTRL_PORT. The new mapping applies from the cycle after that clock edge. Writes to other ports have no effect.
- R9: With neither mem_rd nor mem_wr high, no select is asserted. During an access exactly one select is asserted. mem_wr takes precedence when both are high.
- R10: The boot overlay covers the first BOOT_CYCLES clock cycles after reset is released and then ends. A set ctl[2] does not cut it short. After it ends, 0x0000-0x3FFF is RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_ADDR_W (8) | I/O port address |
| io_wdata | input | 8 | I/O write data; bits 5..0 feed the control register |
| mem_rd | input | 1 | Memory read in progress |
| mem_wr | input | 1 | Memory write in progress |
| mem_addr | input | ADDR_W (16) | CPU memory address |
| ram_sel | output | 1 | Access targets RAM |
| ram_page | output | BANK_W+PAGE_W (7) | 4 KB RAM page index |
| rom_sel | output | 1 | Read targets ROM |
| rom_page | output | PAGE_W-2 (2) | 4 KB ROM page index |
| vid_lo_sel | output | 1 | Access targets low 2 KB of video window |
| vid_hi_sel | output | 1 | Access targets high 2 KB of video window |
| sink_sel | output | 1 | Write to ROM absorbed by the dummy sink |

## Verification
The hardest case to reach from the ports is the end of the boot overlay. It lasts for a set number of cycles after reset and cannot be brought back without another reset. The bench therefore makes the overlay short through its parameter and counts clock edges from reset release. It checks the last cycle where the overlay is still active and the first cycle where it has ended. Before that point it sets the ROM-disable bit, to show that the overlay ignores it. Control writes take effect one edge late, so a separate check samples the old mapping before that edge and the new one after it.

// File: rtl/bmd_pkg.sv
// Package: shared types and control-bit positions for the banked memory map
// decoder. Assumes a six-bit control word; the bit positions below are
// behaviour (software writes them) and are therefore fixed here.
package bmd_pkg;

    localparam int CTL_W       = 6;
    localparam int CTL_BANK0   = 0;
    localparam int CTL_BANK1   = 1;
    localparam int CTL_ROM_OFF = 2;
    localparam int CTL_VID_OFF = 3;
    localparam int CTL_VID_LOW = 4;
    localparam int CTL_BANK2   = 5;

    typedef enum logic [2:0] {
        TGT_RAM  = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_VID  = 3'd2,
        TGT_SINK = 3'd3
    } target_e;

endpackage

// File: rtl/bmd_ctrl_reg.sv
// Module: control register. Captures the low CTL_W bits of an I/O write
// aimed at CTRL_PORT. Assumes a synchronous active-low reset that clears it.
module bmd_ctrl_reg
    import bmd_pkg::*;
#(
    parameter int            IO_ADDR_W = 8,
    parameter int            DATA_W    = 8,
    parameter logic [IO_ADDR_W-1:0] CTRL_PORT = 8'h50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [CTL_W-1:0]     ctl
);

    logic hit;

    // Port match for the write strobe
    always_comb begin
        hit = io_wr && (io_addr == CTRL_PORT);
    end

    // Register update: cleared on reset, loaded on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit) begin
            ctl <= io_wdata[CTL_W-1:0];
        end
    end

endmodule

// File: rtl/bmd_boot_timer.sv
// Module: boot overlay timer. Holds the overlay active for BOOT_CYCLES
// clock edges after reset is released. Assumes BOOT_CYCLES >= 1.
module bmd_boot_timer #(
    parameter int BOOT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic boot
);

    localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BOOT_CYCLES);

    logic [CNT_W-1:0] remain;

    // Countdown: reload during reset, decrement to zero afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= CNT_INIT;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Overlay flag is the non-zero state of the countdown
    always_comb begin
        boot = (remain != '0);
    end

endmodule

// File: rtl/bmd_page_decode.sv
// Module: per-access page decoder. Maps an address plus control word to a
// target with priority video > ROM > RAM. IS_WRITE redirects ROM hits to
// the sink. Purely combinational; assumes PAGE_W >= 3.
module bmd_page_decode
    import bmd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 4,
    parameter int BANK_W   = 3,
    parameter bit IS_WRITE = 1'b0
) (
    input  logic [CTL_W-1:0]         ctl,
    input  logic                     boot,
    input  logic [ADDR_W-1:0]        addr,
    output target_e                  tgt,
    output logic [BANK_W+PAGE_W-1:0] ram_page,
    output logic [PAGE_W-3:0]        rom_page,
    output logic                     vid_hi
);

    localparam int OFF_W = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] VID_PG_TOP = '1;
    localparam logic [PAGE_W-1:0] VID_PG_MID = {1'b1, {(PAGE_W-1){1'b0}}};

    logic [PAGE_W-1:0] page;
    logic [BANK_W-1:0] bank;
    logic              vid_hit;
    logic              rom_hit;
    logic              rom_norm;
    logic              rom_boot;

    // Page number and bank field extraction
    always_comb begin
        page = addr[ADDR_W-1 -: PAGE_W];
        bank = BANK_W'({ctl[CTL_BANK2], ctl[CTL_BANK1], ctl[CTL_BANK0]});
    end

    // Hit detection for video window and ROM ranges
    always_comb begin
        vid_hit  = !ctl[CTL_VID_OFF] &&
                   (page == (ctl[CTL_VID_LOW] ? VID_PG_MID : VID_PG_TOP));
        rom_norm = !ctl[CTL_ROM_OFF] && (page[PAGE_W-1 -: 2] == 2'b10);
        rom_boot = boot && (page[PAGE_W-1 -: 2] == 2'b00);
        rom_hit  = rom_norm || rom_boot;
    end

    // Priority resolution and page outputs
    always_comb begin
        if (vid_hit) begin
            tgt = TGT_VID;
        end else if (rom_hit) begin
            tgt = IS_WRITE ? TGT_SINK : TGT_ROM;
        end else begin
            tgt = TGT_RAM;
        end
        if (page[PAGE_W-1]) begin
            ram_page = {{BANK_W{1'b0}}, page};
        end else begin
            ram_page = {bank, page};
        end
        rom_page = page[PAGE_W-3:0];
        vid_hi   = addr[OFF_W-1];
    end

endmodule

// File: rtl/bank_map_decoder.sv
// Module: top of the banked memory map decoder. Holds the control register
// and boot timer and decodes each access with separate read and write
// decoders. Assumes single-cycle address validity per mem_rd/mem_wr cycle.
module bank_map_decoder
    import bmd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int BANK_W      = 3,
    parameter int IO_ADDR_W   = 8,
    parameter int DATA_W      = 8,
    parameter logic [IO_ADDR_W-1:0] CTRL_PORT = 8'h50,
    parameter int BOOT_CYCLES = 500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_wr,
    input  logic [IO_ADDR_W-1:0]     io_addr,
    input  logic [DATA_W-1:0]        io_wdata,
    input  logic                     mem_rd,
    input  logic                     mem_wr,
    input  logic [ADDR_W-1:0]        mem_addr,
    output logic                     ram_sel,
    output logic [BANK_W+PAGE_W-1:0] ram_page,
    output logic                     rom_sel,
    output logic [PAGE_W-3:0]        rom_page,
    output logic                     vid_lo_sel,
    output logic                     vid_hi_sel,
    output logic                     sink_sel
);

    localparam int NDEC  = 2;
    localparam int RP_W  = BANK_W + PAGE_W;

    logic [CTL_W-1:0] ctl;
    logic             boot;

    target_e          d_tgt    [NDEC];
    logic [RP_W-1:0]  d_rpage  [NDEC];
    logic [PAGE_W-3:0] d_opage [NDEC];
    logic             d_vhi    [NDEC];

    target_e          tgt;
    logic             vhi;
    logic             active;

    bmd_ctrl_reg #(
        .IO_ADDR_W (IO_ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_PORT (CTRL_PORT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .ctl      (ctl)
    );

    bmd_boot_timer #(
        .BOOT_CYCLES (BOOT_CYCLES)
    ) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .boot  (boot)
    );

    // Index 0 decodes reads, index 1 decodes writes
    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        bmd_page_decode #(
            .ADDR_W   (ADDR_W),
            .PAGE_W   (PAGE_W),
            .BANK_W   (BANK_W),
            .IS_WRITE (g == 1)
        ) u_dec (
            .ctl      (ctl),
            .boot     (boot),
            .addr     (mem_addr),
            .tgt      (d_tgt[g]),
            .ram_page (d_rpage[g]),
            .rom_page (d_opage[g]),
            .vid_hi   (d_vhi[g])
        );
    end

    // Pick the decoder matching the access direction, writes first
    always_comb begin
        active   = mem_rd || mem_wr;
        tgt      = mem_wr ? d_tgt[1]   : d_tgt[0];
        ram_page = mem_wr ? d_rpage[1] : d_rpage[0];
        rom_page = mem_wr ? d_opage[1] : d_opage[0];
        vhi      = mem_wr ? d_vhi[1]   : d_vhi[0];
    end

    // One-hot select outputs, gated by an access in progress
    always_comb begin
        ram_sel    = active && (tgt == TGT_RAM);
        rom_sel    = active && (tgt == TGT_ROM);
        sink_sel   = active && (tgt == TGT_SINK);
        vid_lo_sel = active && (tgt == TGT_VID) && !vhi;
        vid_hi_sel = active && (tgt == TGT_VID) && vhi;
    end

endmodule

// File: rtl/bmd_checker.sv
// Module: assertion checker for bank_map_decoder, attached by bind.
module bmd_checker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ram_sel,
    input logic              rom_sel,
    input logic              vid_lo_sel,
    input logic              vid_hi_sel,
    input logic              sink_sel
);

    logic [PAGE_W-1:0] pg;
    assign pg = mem_addr[ADDR_W-1 -: PAGE_W];

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> $countones({ram_sel, rom_sel, vid_lo_sel, vid_hi_sel, sink_sel}) == 1);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr) |-> !(ram_sel || rom_sel || vid_lo_sel || vid_hi_sel || sink_sel));

    // R7
    wr_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !rom_sel);

    // R1
    boot_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && mem_rd && !mem_wr && (pg[PAGE_W-1 -: 2] == 2'b00)) |-> rom_sel);

    // R4
    vid_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_lo_sel || vid_hi_sel) |-> (pg == '1 || pg == {1'b1, {(PAGE_W-1){1'b0}}}));

    // R3
    rom_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel || sink_sel) |-> (pg[PAGE_W-1 -: 2] == 2'b10 || pg[PAGE_W-1 -: 2] == 2'b00));

    // R6
    vid_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_lo_sel |-> !mem_addr[ADDR_W-PAGE_W-1]) and (vid_hi_sel |-> mem_addr[ADDR_W-PAGE_W-1]));

endmodule

bind bank_map_decoder bmd_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .ram_sel    (ram_sel),
    .rom_sel    (rom_sel),
    .vid_lo_sel (vid_lo_sel),
    .vid_hi_sel (vid_hi_sel),
    .sink_sel   (sink_sel)
);

// File: tb/bank_map_decoder_tb.sv
module bank_map_decoder_tb;

    localparam int BOOT = 40;
    localparam logic [7:0] PORT = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = '0;
    logic        ram_sel, rom_sel, vid_lo_sel, vid_hi_sel, sink_sel;
    logic [6:0]  ram_page;
    logic [1:0]  rom_page;

    int n_chk = 0;
    int n_bad = 0;
    int since = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // posedges counted since reset release
    always @(posedge clk) begin
        if (!rst_n) since <= 0;
        else        since <= since + 1;
    end

    bank_map_decoder #(.BOOT_CYCLES(BOOT), .CTRL_PORT(PORT)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .ram_sel(ram_sel), .ram_page(ram_page),
        .rom_sel(rom_sel), .rom_page(rom_page), .vid_lo_sel(vid_lo_sel),
        .vid_hi_sel(vid_hi_sel), .sink_sel(sink_sel)
    );

    // {ctl[5:0], addr[15:0], wr, sel{sink,vhi,vlo,rom,ram}, ram_page[6:0], rom_page[1:0]}
    localparam int NV = 17;
    localparam logic [36:0] VEC [NV] = '{
        {6'h00, 16'h1234, 1'b0, 5'b00001, 7'h01, 2'd0}, // R2 bank 0
        {6'h23, 16'h5ABC, 1'b0, 5'b00001, 7'h75, 2'd0}, // R2 bank 7
        {6'h02, 16'h7000, 1'b0, 5'b00001, 7'h27, 2'd0}, // R2 bank 2
        {6'h00, 16'h8123, 1'b0, 5'b00010, 7'h00, 2'd0}, // R3 rom page 0
        {6'h00, 16'hB456, 1'b0, 5'b00010, 7'h00, 2'd3}, // R3 rom page 3
        {6'h00, 16'hC000, 1'b0, 5'b00001, 7'h0C, 2'd0}, // R2 upper region
        {6'h04, 16'h9000, 1'b0, 5'b00001, 7'h09, 2'd0}, // R3 rom disabled
        {6'h00, 16'hF100, 1'b0, 5'b00100, 7'h00, 2'd0}, // R4/R6 low half
        {6'h00, 16'hF900, 1'b0, 5'b01000, 7'h00, 2'd0}, // R6 high half
        {6'h08, 16'hF900, 1'b0, 5'b00001, 7'h0F, 2'd0}, // R4 video off
        {6'h10, 16'h8200, 1'b0, 5'b00100, 7'h00, 2'd0}, // R5 video over rom
        {6'h10, 16'hF000, 1'b0, 5'b00001, 7'h0F, 2'd0}, // R4 moved away
        {6'h18, 16'h8800, 1'b0, 5'b00010, 7'h00, 2'd0}, // R5 rom over ram
        {6'h00, 16'hA000, 1'b1, 5'b10000, 7'h00, 2'd0}, // R7 write to rom
        {6'h00, 16'hF800, 1'b1, 5'b01000, 7'h00, 2'd0}, // R7 write to video
        {6'h21, 16'h3FFF, 1'b1, 5'b00001, 7'h53, 2'd0}, // R7 write to ram
        {6'h1C, 16'h8000, 1'b0, 5'b00001, 7'h08, 2'd0}  // R3/R4 all off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] sels();
        return {sink_sel, vid_hi_sel, vid_lo_sel, rom_sel, ram_sel};
    endfunction

    task automatic io_write(input logic [7:0] port, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = port; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input logic wr);
        mem_addr = a; mem_rd = !wr; mem_wr = wr;
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: boot overlay active, register zero
        access(16'h2345, 1'b0);
        check("R1 boot sel", sels(), 5'b00010);
        check("R1 boot page", rom_page, 2'd2);
        access(16'hF123, 1'b0);
        check("R1 reset video", sels(), 5'b00100);
        access(16'h1000, 1'b1);
        check("R7 boot write sink", sels(), 5'b10000);
        // R10: rom-off bit does not end the overlay
        io_write(PORT, 8'h04);
        access(16'h0000, 1'b0);
        check("R10 overlay kept", sels(), 5'b00010);
        while (since < BOOT - 1) @(negedge clk);
        #1;
        check("R10 last boot cycle", sels(), 5'b00010);
        @(negedge clk); #1;
        check("R10 overlay ended", sels(), 5'b00001);
        check("R10 ram page", ram_page, 7'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            io_write(PORT, {2'b00, VEC[i][36:31]});
            access(VEC[i][30:15], VEC[i][14]);
            check($sformatf("vec%0d sel", i), sels(), VEC[i][13:9]);
            if (VEC[i][9])  check($sformatf("vec%0d R2 ram_page", i), ram_page, VEC[i][8:2]);
            if (VEC[i][10]) check($sformatf("vec%0d R3 rom_page", i), rom_page, VEC[i][1:0]);
        end

        // R8: other port ignored
        io_write(PORT, 8'h00);
        io_write(8'h51, 8'h08);
        access(16'hF100, 1'b0);
        check("R8 other port ignored", sels(), 5'b00100);
        // R8: new mapping only after the edge
        @(negedge clk);
        io_wr = 1'b1; io_addr = PORT; io_wdata = 8'h08;
        #1;
        check("R8 before edge", sels(), 5'b00100);
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        check("R8 after edge", sels(), 5'b00001);
        // R8: upper data bits ignored
        io_write(PORT, 8'hC0);
        access(16'hF900, 1'b0);
        check("R8 upper bits", sels(), 5'b01000);
        // R9: idle and write precedence
        mem_rd = 1'b0; mem_wr = 1'b0; #1;
        check("R9 idle", sels(), 5'b00000);
        mem_addr = 16'h9000; mem_rd = 1'b1; mem_wr = 1'b1; #1;
        check("R9 write wins", sels(), 5'b10000);
        mem_rd = 1'b0; mem_wr = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule